// File: doc/BRIEF.md
# Operand-collecting computation unit controller

This block sequences one operation through an execution unit from issue until its result is written back. An issue pulse in the idle state latches the operation fields. The unit then raises `busy_o` and requests each source operand it needs over a request/go handshake. It keeps `busy_o` high until the result has been stored, so a result can never be lost.

There are two source ports. Source 0 is skipped when the zero-operand flag is set, and source 1 is skipped when the immediate-valid flag is set. A set read-mask bit skips its port as well. Once every needed operand is held, the unit offers them to the execution unit on a valid/ready stream. The operands stay valid and stable until `exe_ready_i` is seen high, so the execution unit may apply back-pressure for any number of cycles.

The unit then accepts exactly one result on a second valid/ready stream. `exe_res_ready_o` is high only while one result is outstanding. Last, the unit requests a register write with a second request/go handshake and goes idle after the write go pulse.

Top module: `opcu_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy_o`, `src_rel_o`, `exe_valid_o`, `exe_res_ready_o` and `wr_rel_o` are all low.
- R2: `busy_o` rises only in the cycle after `issue_i` was sampled high while idle. It stays high until the operation ends. An `issue_i` pulse sampled while busy is ignored.
- R3: In the cycle after an accepted issue, `src_rel_o[p]` is high for each source that is read. It stays high through any number of stall cycles until `src_go_i[p]` is sampled high.
- R4: Source 0 (bit 0) is read unless the zero-operand flag or `rd_mask_i[0]` is set; a skipped source 0 has value 0. Source 1 (bit 1) is read unless the immediate-valid flag or `rd_mask_i[1]` is set. When the immediate-valid flag is set, operand B is the immediate; when only the mask is set, operand B is 0.
- R5: `src_rel_o[p]` falls in the cycle after the go pulse. It does not rise again within the same operation.
- R6: Source data is captured only in a cycle where both `src_go_i[p]` and `src_rel_o[p]` are high. A go pulse while the request is low has no effect.
- R7: `exe_valid_o` rises only after all needed operands are captured, one cycle after the last capture. Operand A is the source-0 value, bitwise inverted when the invert flag is set. While `exe_valid_o` is high and `exe_ready_i` is low, `exe_valid_o`, `exe_a_o` and `exe_b_o` hold.
- R8: `exe_res_ready_o` is high only between the operand handoff and the capture of one result. `wr_rel_o` rises in the cycle after that capture. While `wr_rel_o` is high, `wr_dat_o` shows the captured result.
- R9: A `wr_go_i` pulse sampled while `wr_rel_o` is high makes `busy_o` and `wr_rel_o` low in the next cycle.
- R10: Operation fields and the read mask are sampled only in the issue cycle. Later changes on those inputs do not affect the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue pulse, taken only while idle |
| kind_i | input | KW | Operation type, passed to the execution unit |
| inv_i | input | 1 | Invert operand A |
| imm_i | input | DW | Immediate value |
| imm_vld_i | input | 1 | Immediate replaces source 1 |
| zero_a_i | input | 1 | Operand A is zero; source 0 not read |
| rd_mask_i | input | 2 | Per-source read suppression |
| busy_o | output | 1 | Operation in flight |
| src_rel_o | output | 2 | Source read requests |
| src_go_i | input | 2 | Source read go pulses |
| src_dat_i | input | 2*DW | Source data, port p at bits p*DW upward |
| exe_valid_o | output | 1 | Operands valid to execution unit |
| exe_ready_i | input | 1 | Execution unit accepts operands |
| exe_a_o | output | DW | Operand A |
| exe_b_o | output | DW | Operand B |
| exe_kind_o | output | KW | Latched operation type |
| exe_res_valid_i | input | 1 | Result valid from execution unit |
| exe_res_ready_o | output | 1 | Result accepted |
| exe_res_i | input | DW | Result value |
| wr_rel_o | output | 1 | Result write request |
| wr_go_i | input | 1 | Result write go pulse |
| wr_dat_o | output | DW | Result to write |

## Verification
Every response is due exactly one clock after the edge that samples its cause:
- `busy_o` and the source requests follow the issue edge.
- A source request drops one edge after its go pulse.
- `exe_valid_o` follows the last operand capture.
- `exe_res_ready_o` follows the handoff.
- `wr_rel_o` follows the result capture.
- `busy_o` falls one edge after the write go pulse.

The bench drives every input at the falling edge and reads every output at the next falling edge, so each check lands in the one cycle where the response is due. Operand values are checked at the handoff. The written result is checked in the cycle of the write go pulse. Stray issue and go pulses are injected during the back-pressure window, and the operands are read again at the next falling edge to confirm they were ignored.

// File: rtl/opcu_pkg.sv
package opcu_pkg;

  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_AWAIT   = 2'd2,
    PH_STORE   = 2'd3
  } opcu_phase_e;

  // Which sources need a register read for a freshly issued operation.
  function automatic logic [NSRC-1:0] read_need(input logic zero_a,
                                                input logic imm_vld,
                                                input logic [NSRC-1:0] mask);
    logic [NSRC-1:0] n;
    n[0] = !zero_a && !mask[0];
    n[1] = !imm_vld && !mask[1];
    return n;
  endfunction

endpackage

// File: rtl/opcu_op_hold.sv
module opcu_op_hold #(
  parameter int DW = 16,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [KW-1:0] kind_i,
  input  logic          inv_i,
  input  logic [DW-1:0] imm_i,
  input  logic          imm_vld_i,
  output logic [KW-1:0] kind_q,
  output logic          inv_q,
  output logic [DW-1:0] imm_q,
  output logic          imm_vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= '0;
      inv_q     <= 1'b0;
      imm_q     <= '0;
      imm_vld_q <= 1'b0;
    end else if (load_i) begin
      kind_q    <= kind_i;
      inv_q     <= inv_i;
      imm_q     <= imm_i;
      imm_vld_q <= imm_vld_i;
    end
  end

endmodule

// File: rtl/opcu_src_slot.sv
module opcu_src_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          need_i,
  input  logic          go_i,
  input  logic [DW-1:0] dat_i,
  output logic          rel_o,
  output logic          got_o,
  output logic [DW-1:0] val_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_o <= 1'b0;
      got_o <= 1'b0;
      val_o <= '0;
    end else if (start_i) begin
      rel_o <= need_i;
      got_o <= !need_i;
      val_o <= '0;
    end else if (rel_o && go_i) begin
      rel_o <= 1'b0;
      got_o <= 1'b1;
      val_o <= dat_i;
    end
  end

endmodule

// File: rtl/opcu_res_slot.sv
module opcu_res_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_i,
  output logic          res_ready_o,
  input  logic          wr_go_i,
  output logic          wr_rel_o,
  output logic [DW-1:0] wr_dat_o
);

  logic full_q;

  assign res_ready_o = arm_i && !full_q;
  assign wr_rel_o    = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      wr_dat_o <= '0;
    end else if (res_valid_i && res_ready_o) begin
      full_q   <= 1'b1;
      wr_dat_o <= res_i;
    end else if (full_q && wr_go_i) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/opcu_top.sv
module opcu_top
  import opcu_pkg::*;
#(
  parameter int DW = 16,
  parameter int KW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic [KW-1:0]   kind_i,
  input  logic            inv_i,
  input  logic [DW-1:0]   imm_i,
  input  logic            imm_vld_i,
  input  logic            zero_a_i,
  input  logic [1:0]      rd_mask_i,
  output logic            busy_o,
  output logic [1:0]      src_rel_o,
  input  logic [1:0]      src_go_i,
  input  logic [2*DW-1:0] src_dat_i,
  output logic            exe_valid_o,
  input  logic            exe_ready_i,
  output logic [DW-1:0]   exe_a_o,
  output logic [DW-1:0]   exe_b_o,
  output logic [KW-1:0]   exe_kind_o,
  input  logic            exe_res_valid_i,
  output logic            exe_res_ready_o,
  input  logic [DW-1:0]   exe_res_i,
  output logic            wr_rel_o,
  input  logic            wr_go_i,
  output logic [DW-1:0]   wr_dat_o
);

  opcu_phase_e     phase_q;
  logic            start;
  logic [NSRC-1:0] need_now;
  logic [NSRC-1:0] got;
  logic [DW-1:0]   val [NSRC];
  logic            inv_q;
  logic [DW-1:0]   imm_q;
  logic            imm_vld_q;
  logic            all_got;
  logic            res_take;

  assign start    = issue_i && (phase_q == PH_IDLE);
  assign need_now = read_need(zero_a_i, imm_vld_i, rd_mask_i);

  opcu_op_hold #(.DW(DW), .KW(KW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start),
    .kind_i    (kind_i),
    .inv_i     (inv_i),
    .imm_i     (imm_i),
    .imm_vld_i (imm_vld_i),
    .kind_q    (exe_kind_o),
    .inv_q     (inv_q),
    .imm_q     (imm_q),
    .imm_vld_q (imm_vld_q)
  );

  for (genvar p = 0; p < NSRC; p++) begin : g_src
    opcu_src_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .start_i (start),
      .need_i  (need_now[p]),
      .go_i    (src_go_i[p]),
      .dat_i   (src_dat_i[p*DW +: DW]),
      .rel_o   (src_rel_o[p]),
      .got_o   (got[p]),
      .val_o   (val[p])
    );
  end

  assign all_got     = &got;
  assign exe_valid_o = (phase_q == PH_COLLECT) && all_got;
  assign exe_a_o     = inv_q ? ~val[0] : val[0];
  assign exe_b_o     = imm_vld_q ? imm_q : val[1];
  assign busy_o      = (phase_q != PH_IDLE);
  assign res_take    = exe_res_valid_i && exe_res_ready_o;

  opcu_res_slot #(.DW(DW)) u_res (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (phase_q == PH_AWAIT),
    .res_valid_i (exe_res_valid_i),
    .res_i       (exe_res_i),
    .res_ready_o (exe_res_ready_o),
    .wr_go_i     (wr_go_i),
    .wr_rel_o    (wr_rel_o),
    .wr_dat_o    (wr_dat_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:    if (issue_i) phase_q <= PH_COLLECT;
        PH_COLLECT: if (exe_valid_o && exe_ready_i) phase_q <= PH_AWAIT;
        PH_AWAIT:   if (res_take) phase_q <= PH_STORE;
        PH_STORE:   if (wr_rel_o && wr_go_i) phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opcu_chk.sv
module opcu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_i,
  input logic          busy_o,
  input logic [1:0]    src_rel_o,
  input logic [1:0]    src_go_i,
  input logic          exe_valid_o,
  input logic          exe_ready_i,
  input logic [DW-1:0] exe_a_o,
  input logic [DW-1:0] exe_b_o,
  input logic          exe_res_ready_o,
  input logic          wr_rel_o,
  input logic          wr_go_i
);

  AST_BUSY_FROM_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(issue_i)); // R2
  AST_REL_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|src_rel_o) |-> busy_o); // R3
  AST_REL0_RISE_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $rose(src_rel_o[0]) |-> ($past(issue_i) && !$past(busy_o))); // R3
  AST_REL0_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src_rel_o[0] && !src_go_i[0]) |=> src_rel_o[0]); // R3
  AST_REL1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src_rel_o[1] && !src_go_i[1]) |=> src_rel_o[1]); // R3
  AST_REL0_DROP: assert property (@(posedge clk) disable iff (rst)
    (src_rel_o[0] && src_go_i[0]) |=> !src_rel_o[0]); // R5
  AST_REL1_DROP: assert property (@(posedge clk) disable iff (rst)
    (src_rel_o[1] && src_go_i[1]) |=> !src_rel_o[1]); // R5
  AST_VALID_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
    exe_valid_o |-> !(|src_rel_o)); // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exe_valid_o && !exe_ready_i) |=>
      (exe_valid_o && $stable(exe_a_o) && $stable(exe_b_o))); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    exe_res_ready_o |-> (!wr_rel_o && !exe_valid_o)); // R8
  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (wr_rel_o && wr_go_i) |=> (!busy_o && !wr_rel_o)); // R9

endmodule

bind opcu_top opcu_chk #(.DW(DW)) u_opcu_chk (
  .clk             (clk),
  .rst             (rst),
  .issue_i         (issue_i),
  .busy_o          (busy_o),
  .src_rel_o       (src_rel_o),
  .src_go_i        (src_go_i),
  .exe_valid_o     (exe_valid_o),
  .exe_ready_i     (exe_ready_i),
  .exe_a_o         (exe_a_o),
  .exe_b_o         (exe_b_o),
  .exe_res_ready_o (exe_res_ready_o),
  .wr_rel_o        (wr_rel_o),
  .wr_go_i         (wr_go_i)
);

// File: tb/test_opcu_top.sv
module test_opcu_top;
  localparam int DW = 16;
  localparam int KW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic            issue_i = 0;
  logic [KW-1:0]   kind_i = 0;
  logic            inv_i = 0;
  logic [DW-1:0]   imm_i = 0;
  logic            imm_vld_i = 0;
  logic            zero_a_i = 0;
  logic [1:0]      rd_mask_i = 0;
  logic            busy_o;
  logic [1:0]      src_rel_o;
  logic [1:0]      src_go_i = 0;
  logic [2*DW-1:0] src_dat_i = 0;
  logic            exe_valid_o;
  logic            exe_ready_i = 0;
  logic [DW-1:0]   exe_a_o, exe_b_o;
  logic [KW-1:0]   exe_kind_o;
  logic            exe_res_valid_i = 0;
  logic            exe_res_ready_o;
  logic [DW-1:0]   exe_res_i = 0;
  logic            wr_rel_o;
  logic            wr_go_i = 0;
  logic [DW-1:0]   wr_dat_o;

  opcu_top #(.DW(DW), .KW(KW)) i_opcu_top (.*);

  int n_chk = 0, n_bad = 0, n_ops = 0, n_wr = 0;
  int n_src [2] = '{0, 0};
  int n_skip [2] = '{0, 0};
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exe_fn(input logic [KW-1:0] k, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (k)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a | b;
    endcase
  endfunction

  task automatic scramble();
    kind_i = KW'($urandom); inv_i = 1'($urandom); imm_i = DW'($urandom);
    imm_vld_i = 1'($urandom); zero_a_i = 1'($urandom); rd_mask_i = 2'($urandom);
  endtask

  // One operation; called and returns at a falling edge.
  task automatic run_op(input logic [KW-1:0] kind, input logic inv, input logic [DW-1:0] imm,
                        input logic immv, input logic za, input logic [1:0] msk,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input int d0, input int d1, input int dr, input int lat, input int dw,
                        input bit poke);
    logic [1:0] need;
    logic [DW-1:0] opv [2];
    logic [DW-1:0] ea, eb, er, xa, xb;
    int cnt [2];
    bit gone [2], cap [2], golast [2];
    int cr, cl, cw;
    bit rlast, handed, vlast, resd, wlast, fin, seenv, pokelast;
    need[0] = !za && !msk[0];
    need[1] = !immv && !msk[1];
    opv[0] = a; opv[1] = b;
    cnt[0] = d0; cnt[1] = d1; cr = dr; cl = lat; cw = dw;
    gone = '{0, 0}; cap = '{0, 0}; golast = '{0, 0};
    rlast = 0; handed = 0; vlast = 0; resd = 0; wlast = 0; fin = 0; seenv = 0; pokelast = 0;
    xa = '0; xb = '0;
    ea = need[0] ? a : '0;
    if (inv) ea = ~ea;
    eb = immv ? imm : (msk[1] ? '0 : b);
    er = exe_fn(kind, ea, eb);

    chk(busy_o == 1'b0, "R2 idle before issue", busy_o, 0);
    issue_i = 1; kind_i = kind; inv_i = inv; imm_i = imm; imm_vld_i = immv;
    zero_a_i = za; rd_mask_i = msk;
    @(negedge clk);
    issue_i = 0;
    scramble();  // R10: later field changes must not matter
    chk(busy_o == 1'b1, "R2 busy after issue", busy_o, 1);
    chk(src_rel_o == need, "R3 R4 requests after issue", src_rel_o, need);
    n_ops++;
    for (int p = 0; p < 2; p++) if (!need[p]) n_skip[p]++;

    for (int it = 0; it < 120; it++) begin
      if (wlast) begin
        wr_go_i = 0;
        chk(!busy_o && !wr_rel_o, "R9 idle after write go", {busy_o, wr_rel_o}, 0);
        fin = 1;
        break;
      end
      if (!busy_o) chk(0, "R2 busy dropped early", busy_o, 1);
      if (pokelast) begin
        pokelast = 0; issue_i = 0; src_go_i = 0;
        chk(exe_a_o == ea && exe_b_o == eb, "R6 R2 stray pulses ignored", {exe_a_o, exe_b_o}, {ea, eb});
      end
      for (int p = 0; p < 2; p++) begin
        if (golast[p]) begin
          golast[p] = 0; cap[p] = 1; src_go_i[p] = 0;
          src_dat_i[p*DW +: DW] = DW'($urandom);
          chk(!src_rel_o[p], "R5 request drops after go", src_rel_o[p], 0);
        end else if (gone[p] || !need[p]) begin
          if (src_rel_o[p]) chk(0, "R5 R4 unexpected request", src_rel_o[p], 0);
        end else if (src_rel_o[p]) begin
          if (cnt[p] == 0) begin
            src_go_i[p] = 1; src_dat_i[p*DW +: DW] = opv[p];
            gone[p] = 1; golast[p] = 1; n_src[p]++;
          end else cnt[p]--;
        end else chk(0, "R3 request lost during stall", src_rel_o[p], 1);
      end
      if (rlast) begin
        rlast = 0; exe_ready_i = 0; handed = 1;
        chk(!exe_valid_o, "R7 valid ends after handoff", exe_valid_o, 0);
      end else if (exe_valid_o && !handed) begin
        if (!seenv) begin
          seenv = 1;
          chk((cap[0] || !need[0]) && (cap[1] || !need[1]), "R7 valid after all operands",
              {cap[0], cap[1]}, need);
          chk(exe_a_o == ea, "R4 R7 operand A", exe_a_o, ea);
          chk(exe_b_o == eb, "R4 operand B", exe_b_o, eb);
          chk(exe_kind_o == kind, "R10 kind held", exe_kind_o, kind);
          if (poke && cr > 0) begin
            pokelast = 1; issue_i = 1; src_go_i = 2'b11; src_dat_i = {2{DW'($urandom)}};
          end
        end
        if (cr == 0) begin
          exe_ready_i = 1; rlast = 1; xa = exe_a_o; xb = exe_b_o;
        end else cr--;
      end
      if (!handed && exe_res_ready_o) chk(0, "R8 result ready before handoff", 1, 0);
      if (vlast) begin
        vlast = 0; exe_res_valid_i = 0; resd = 1; exe_res_i = DW'($urandom);
        chk(wr_rel_o, "R8 write request after result", wr_rel_o, 1);
      end else if (handed && !resd) begin
        if (cl == 0) begin
          chk(exe_res_ready_o, "R8 result ready", exe_res_ready_o, 1);
          exe_res_valid_i = 1; exe_res_i = exe_fn(kind, xa, xb); vlast = 1;
        end else cl--;
      end
      if (!resd && wr_rel_o) chk(0, "R8 early write request", 1, 0);
      if (wr_rel_o && !wlast) begin
        if (resd && exe_res_ready_o) chk(0, "R8 second result accepted", 1, 0);
        if (cw == 0) begin
          chk(wr_dat_o == er, "R8 R10 written result", wr_dat_o, er);
          wr_go_i = 1; wlast = 1; n_wr++;
        end else cw--;
      end
      @(negedge clk);
    end
    if (!fin) chk(0, "R9 operation never completed", 0, 1);
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!busy_o && src_rel_o == 0 && !wr_rel_o, "R2 stays idle", {busy_o, src_rel_o, wr_rel_o}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin : main
    void'($urandom(32'h0c0ffee1));
    repeat (3) @(negedge clk);
    chk(!busy_o && src_rel_o == 0 && !exe_valid_o && !exe_res_ready_o && !wr_rel_o,
        "R1 in reset", {busy_o, src_rel_o, exe_valid_o, exe_res_ready_o, wr_rel_o}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && src_rel_o == 0 && !exe_valid_o && !exe_res_ready_o && !wr_rel_o,
        "R1 after reset", {busy_o, src_rel_o, exe_valid_o, exe_res_ready_o, wr_rel_o}, 0);
    idle_check(2);

    // directed corners
    run_op(2'd0, 0, 16'h0, 0, 0, 2'b00, 16'd5, 16'd2, 0, 0, 0, 0, 0, 0);   // all zero delay
    run_op(2'd0, 0, 16'd8, 1, 1, 2'b00, 16'd5, 16'd2, 0, 2, 0, 0, 0, 0);   // R4 no reads
    run_op(2'd0, 1, 16'h0, 0, 0, 2'b00, 16'd5, 16'd2, 1, 2, 0, 1, 0, 0);   // invert
    run_op(2'd1, 1, 16'h0, 0, 1, 2'b00, 16'd5, 16'd2, 0, 0, 1, 0, 1, 0);   // zero + invert
    run_op(2'd3, 0, 16'h77, 0, 0, 2'b11, 16'h1234, 16'h4321, 0, 0, 0, 3, 4, 0); // R4 masked
    run_op(2'd2, 0, 16'h55, 1, 0, 2'b10, 16'hA5A5, 16'h1111, 9, 0, 3, 2, 2, 1); // stall + poke
    idle_check(2);

    for (int i = 0; i < 300; i++) begin
      run_op(KW'($urandom), 1'($urandom), DW'($urandom), ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00,
             DW'($urandom), DW'($urandom), $urandom_range(0, 4), $urandom_range(0, 4),
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
             ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 2) == 0) idle_check($urandom_range(1, 2));
    end

    for (int p = 0; p < 2; p++)
      chk(n_src[p] + n_skip[p] == n_ops, "R4 reads plus skips equal operations",
          n_src[p] + n_skip[p], n_ops);
    chk(n_wr == n_ops, "R8 one write per operation", n_wr, n_ops);

    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end
endmodule